// File: doc/BRIEF.md
# Indexed Port Memory Bridge

This block puts a byte memory behind two access paths. The first is a narrow byte port with a four-slot window. Two slots build a 16-bit pointer one byte at a time. A third slot moves data to or from the byte that the pointer selects. Writing through that data slot sends the pointer back to zero, so every indexed write has to load a fresh address first. The second path is a direct memory-mapped port. It takes byte, halfword or word requests and runs them as a series of single-byte memory cycles, with the most significant byte at the lowest address.

Two 16-byte regions of the memory can be fenced off. Each region has its own protection bit, and a toggle command inverts that bit. While a region is fenced, writes to it are dropped and reads from it return all ones. The same applies to any address at or above the configured memory size. Both paths go through the same check, and it is made for every single byte.

Top module: `idx_mem_bridge`

## Requirements
- R1: A port write to slot 0 replaces bits 7:0 of the pointer, and a port write to slot 1 replaces bits 15:8. The other pointer byte keeps its value. Slot 2 has no effect.
- R2: A port write to slot 3 stores the data byte at the pointer address. After the same clock edge the pointer reads 0x0000.
- R3: A port read accepted at a clock edge raises `pio_rvalid` for one cycle after the next edge. `pio_rdata` then holds the addressed byte for slot 3, or 0xFF for slots 0, 1 and 2.
- R4: While protection bit 0 is set, addresses 0x20 to 0x2F are fenced. While protection bit 1 is set, addresses 0x30 to 0x3F are fenced. A write to a fenced byte is dropped, and a read of a fenced byte returns 0xFF.
- R5: A toggle command (`lock_tgl_valid` with `lock_tgl_sel` choosing the bit) inverts the selected protection bit.
- R6: Reset clears the pointer and both protection bits. Memory contents are not reset.
- R7: `mm_size` is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. An access of N bytes covers A to A+N-1, with address arithmetic wrapping at 16 bits. Byte A carries the most significant data byte. Read data is right-aligned in `mm_rdata`. `mm_done` pulses for one cycle at the (N+1)th clock edge after the edge that accepts `mm_req`.
- R8: Addresses at or above MEM_BYTES do not alias onto the memory. A write there is dropped, and a read there returns 0xFF.
- R9: A multi-byte access applies the fencing check to each byte separately. Unfenced bytes complete normally.
- R10: While `mm_busy` is high, port requests and new `mm_req` pulses are ignored. The pointer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pio_valid | input | 1 | Byte-port request strobe |
| pio_we | input | 1 | 1 = write, 0 = read |
| pio_off | input | 2 | Window slot |
| pio_wdata | input | 8 | Byte-port write data |
| pio_rvalid | output | 1 | Byte-port read data valid |
| pio_rdata | output | 8 | Byte-port read data |
| lock_tgl_valid | input | 1 | Protection toggle strobe |
| lock_tgl_sel | input | 1 | Protection bit to invert |
| mm_req | input | 1 | Memory-mapped request strobe |
| mm_we | input | 1 | 1 = write, 0 = read |
| mm_size | input | 2 | Access width code |
| mm_addr | input | 16 | Lowest byte address |
| mm_wdata | input | 32 | Write data, right-aligned |
| mm_busy | output | 1 | Sequence in progress |
| mm_done | output | 1 | One-cycle completion pulse |
| mm_rdata | output | 32 | Read data, right-aligned |

## Verification
A stale or corrupted pointer gives the wrong byte on the next slot-3 read, two edges after that read is accepted. A pointer that fails to clear after a slot-3 write shows up on the very next unaddressed access. A protection bit in the wrong state turns real data into 0xFF, or 0xFF into real data, within the same two-edge read latency. A sequencer that steps the wrong way or drops a byte gives a misordered `mm_rdata`, or moves the `mm_done` pulse away from edge N+1. Both show on the completing access itself.

// File: rtl/idxb_pkg.sv
package idxb_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/idxb_lock_check.sv
module idxb_lock_check #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 256,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LOCKS-1:0] lock_bits,
  output logic                 allowed
);
  logic [NUM_LOCKS-1:0] hit;
  logic [31:0]          addr_ext;

  assign addr_ext = 32'(addr);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
    localparam int LO = LOCK_BASE + i * LOCK_SPAN;
    localparam int HI = LO + LOCK_SPAN;
    assign hit[i] = lock_bits[i] && (addr_ext >= 32'(LO)) && (addr_ext < 32'(HI));
  end

  assign allowed = (addr_ext < 32'(MEM_BYTES)) && (hit == '0);
endmodule

// File: rtl/idxb_ram.sv
module idxb_ram #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/idxb_mm_seq.sv
module idxb_mm_seq
  import idxb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              issue_valid,
  output logic              issue_we,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [7:0]        issue_wdata,
  input  logic              collect_valid,
  input  logic [7:0]        collect_byte,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata
);
  seq_state_e        st_q;
  logic [1:0]        idx_q;
  logic [2:0]        n_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       wd_q;
  logic              we_q;
  logic [5:0]        shift;

  assign busy        = (st_q != SQ_IDLE);
  assign issue_valid = (st_q == SQ_ISSUE);
  assign issue_we    = we_q;
  assign issue_addr  = base_q + ADDR_W'(idx_q);
  assign shift       = {n_q - 3'd1 - {1'b0, idx_q}, 3'b000};
  assign issue_wdata = 8'(wd_q >> shift);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      n_q    <= 3'd1;
      base_q <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        SQ_IDLE: if (req) begin
          base_q <= addr;
          we_q   <= we;
          wd_q   <= wdata;
          n_q    <= size_to_bytes(size);
          idx_q  <= '0;
          rdata  <= '0;
          st_q   <= SQ_ISSUE;
        end
        SQ_ISSUE: begin
          idx_q <= idx_q + 2'd1;
          if ({1'b0, idx_q} == n_q - 3'd1) st_q <= SQ_WAIT;
        end
        default: begin
          st_q <= SQ_IDLE;
          done <= 1'b1;
        end
      endcase
      if (collect_valid) rdata <= {rdata[23:0], collect_byte};
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/idx_mem_bridge.sv
module idx_mem_bridge #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 256,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int NUM_LOCKS = 2,
  localparam int AW        = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pio_valid,
  input  logic              pio_we,
  input  logic [1:0]        pio_off,
  input  logic [7:0]        pio_wdata,
  output logic              pio_rvalid,
  output logic [7:0]        pio_rdata,
  input  logic              lock_tgl_valid,
  input  logic              lock_tgl_sel,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [1:0]        mm_size,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [31:0]       mm_wdata,
  output logic              mm_busy,
  output logic              mm_done,
  output logic [31:0]       mm_rdata
);
  logic [ADDR_W-1:0]    ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic                 pio_acc, pio_data;
  logic                 seq_v, seq_we;
  logic [ADDR_W-1:0]    seq_addr;
  logic [7:0]           seq_wd;
  logic [ADDR_W-1:0]    iss_addr;
  logic                 iss_v, iss_we, iss_ok;
  logic [7:0]           iss_wd, ram_q;
  logic                 s1_pio_rd, s1_mm, s1_ff;
  logic [7:0]           s1_byte;

  assign pio_acc  = pio_valid && !mm_busy;
  assign pio_data = pio_acc && (pio_off == 2'd3);

  assign iss_v    = seq_v || pio_data;
  assign iss_addr = seq_v ? seq_addr : ptr_q;
  assign iss_we   = seq_v ? seq_we : pio_we;
  assign iss_wd   = seq_v ? seq_wd : pio_wdata;

  idxb_lock_check #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_chk (
    .addr(iss_addr), .lock_bits(lock_q), .allowed(iss_ok)
  );

  idxb_ram #(.DEPTH(MEM_BYTES)) u_ram (
    .clk(clk), .we(iss_v && iss_we && iss_ok), .addr(iss_addr[AW-1:0]),
    .wdata(iss_wd), .q(ram_q)
  );

  idxb_mm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .req(mm_req), .we(mm_we), .size(mm_size),
    .addr(mm_addr), .wdata(mm_wdata),
    .issue_valid(seq_v), .issue_we(seq_we), .issue_addr(seq_addr),
    .issue_wdata(seq_wd),
    .collect_valid(s1_mm), .collect_byte(s1_byte),
    .busy(mm_busy), .done(mm_done), .rdata(mm_rdata)
  );

  assign s1_byte = s1_ff ? 8'hFF : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      lock_q     <= '0;
      s1_pio_rd  <= 1'b0;
      s1_mm      <= 1'b0;
      s1_ff      <= 1'b0;
      pio_rvalid <= 1'b0;
      pio_rdata  <= 8'hFF;
    end else begin
      if (pio_acc && pio_we) begin
        case (pio_off)
          2'd0:    ptr_q[7:0]        <= pio_wdata;
          2'd1:    ptr_q[ADDR_W-1:8] <= pio_wdata[ADDR_W-9:0];
          2'd3:    ptr_q             <= '0;
          default: ;
        endcase
      end
      if (lock_tgl_valid) lock_q[lock_tgl_sel] <= ~lock_q[lock_tgl_sel];
      s1_pio_rd  <= pio_acc && !pio_we;
      s1_mm      <= seq_v;
      s1_ff      <= seq_v ? !iss_ok : !(pio_data && iss_ok);
      pio_rvalid <= s1_pio_rd;
      if (s1_pio_rd) pio_rdata <= s1_byte;
    end
  end

  assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    (pio_valid && !mm_busy && !pio_we) |=> ##1 pio_rvalid);
  assert_fenced_read_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_pio_rd && s1_ff) |=> (pio_rdata == 8'hFF));
  assert_ptr_held_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mm_busy |=> $stable(ptr_q));
endmodule

// File: tb/idx_mem_bridge_test.sv
`timescale 1ns/1ps
module idx_mem_bridge_test;
  localparam int MEMB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pio_valid = 0, pio_we = 0;
  logic [1:0] pio_off = 0;
  logic [7:0] pio_wdata = 0;
  logic pio_rvalid;
  logic [7:0] pio_rdata;
  logic lock_tgl_valid = 0, lock_tgl_sel = 0;
  logic mm_req = 0, mm_we = 0;
  logic [1:0] mm_size = 0;
  logic [15:0] mm_addr = 0;
  logic [31:0] mm_wdata = 0;
  logic mm_busy, mm_done;
  logic [31:0] mm_rdata;

  int checks = 0, fails = 0;
  logic [7:0] expm [MEMB];
  logic [1:0] lk = 2'b00;

  always #2.5 clk = ~clk;

  idx_mem_bridge uut (
    .clk(clk), .rst(rst), .pio_valid(pio_valid), .pio_we(pio_we),
    .pio_off(pio_off), .pio_wdata(pio_wdata), .pio_rvalid(pio_rvalid),
    .pio_rdata(pio_rdata), .lock_tgl_valid(lock_tgl_valid),
    .lock_tgl_sel(lock_tgl_sel), .mm_req(mm_req), .mm_we(mm_we),
    .mm_size(mm_size), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_busy(mm_busy), .mm_done(mm_done), .mm_rdata(mm_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic fenced(input logic [15:0] a);
    return (lk[0] && a >= 16'h20 && a <= 16'h2F) || (lk[1] && a >= 16'h30 && a <= 16'h3F);
  endfunction

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    if (a >= 16'(MEMB) || fenced(a)) return 8'hFF;
    return expm[a[7:0]];
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    if (!(a >= 16'(MEMB) || fenced(a))) expm[a[7:0]] = d;
  endtask

  task automatic pio_wr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk); pio_valid = 1; pio_we = 1; pio_off = off; pio_wdata = d;
    @(posedge clk); @(negedge clk); pio_valid = 0; pio_we = 0;
  endtask

  task automatic pio_rd(input logic [1:0] off, output logic [7:0] d, output logic v);
    @(negedge clk); pio_valid = 1; pio_we = 0; pio_off = off;
    @(posedge clk); @(negedge clk); pio_valid = 0;
    @(posedge clk); @(negedge clk); d = pio_rdata; v = pio_rvalid;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    pio_wr(2'd0, a[7:0]);
    pio_wr(2'd1, a[15:8]);
  endtask

  task automatic toggle(input logic s);
    @(negedge clk); lock_tgl_valid = 1; lock_tgl_sel = s;
    @(posedge clk); @(negedge clk); lock_tgl_valid = 0;
    lk[s] = ~lk[s];
  endtask

  task automatic mm_op(input logic [1:0] sz, input logic w, input logic [15:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk); mm_req = 1; mm_we = w; mm_size = sz; mm_addr = a; mm_wdata = wd;
    @(posedge clk); @(negedge clk); mm_req = 0;
    lat = 1;
    while (!mm_done && lat < 50) begin @(negedge clk); lat++; end
    rd = mm_rdata;
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic mm_check(input string req, input logic [1:0] sz, input logic w,
                          input logic [15:0] a, input logic [31:0] wd);
    logic [31:0] rd, expv;
    int lat, n;
    n = nb(sz);
    expv = 0;
    for (int k = 0; k < n; k++) expv = (expv << 8) | 32'(model_rd(a + 16'(k)));
    mm_op(sz, w, a, wd, rd, lat);
    chk({req, " latency"}, 32'(lat), 32'(n + 2));
    if (w) begin
      for (int k = 0; k < n; k++) model_wr(a + 16'(k), 8'(wd >> (8 * (n - 1 - k))));
    end else chk({req, " data"}, rd, expv);
  endtask

  task automatic rd_at(input string req, input logic [15:0] a);
    logic [7:0] d; logic v;
    set_ptr(a);
    pio_rd(2'd3, d, v);
    chk({req, " rvalid"}, 32'(v), 32'd1);
    chk(req, 32'(d), 32'(model_rd(a)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] d; logic v; logic [31:0] rd; int lat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // dirty state, then reset again: R6
    toggle(1'b0);
    pio_wr(2'd0, 8'h44);
    @(negedge clk); rst = 1; @(posedge clk); @(negedge clk); rst = 0; lk = 2'b00;
    chk("R6 rvalid idle", 32'(pio_rvalid), 0);
    chk("R6 busy idle", 32'(mm_busy), 0);
    chk("R6 done idle", 32'(mm_done), 0);
    pio_wr(2'd3, 8'h5A);
    expm[0] = 8'h5A;
    mm_op(2'd0, 1'b0, 16'h0000, 0, rd, lat);
    chk("R6 pointer cleared", rd, 32'h5A);
    mm_op(2'd0, 1'b1, 16'h0025, 32'hC3, rd, lat);
    mm_op(2'd0, 1'b0, 16'h0025, 0, rd, lat);
    chk("R6 locks cleared", rd, 32'hC3);

    // fill and sweep: R1 R2 R3
    for (int a = 0; a < MEMB; a++) begin
      set_ptr(16'(a));
      pio_wr(2'd3, 8'((a * 37 + 11) ^ (a >> 3)));
      expm[a] = 8'((a * 37 + 11) ^ (a >> 3));
    end
    for (int a = 0; a < MEMB; a++) rd_at("R1 R3 sweep", 16'(a));

    set_ptr(16'h0034); pio_wr(2'd0, 8'h56);
    pio_rd(2'd3, d, v); chk("R1 low byte only", 32'(d), 32'(expm[8'h56]));
    set_ptr(16'h1280); pio_wr(2'd1, 8'h00);
    pio_rd(2'd3, d, v); chk("R1 high byte only", 32'(d), 32'(expm[8'h80]));
    set_ptr(16'h0081); pio_wr(2'd2, 8'h07);
    pio_rd(2'd3, d, v); chk("R1 slot2 no effect", 32'(d), 32'(expm[8'h81]));

    set_ptr(16'h0045); pio_wr(2'd3, 8'h9C); expm[8'h45] = 8'h9C;
    pio_rd(2'd3, d, v); chk("R2 pointer zero after write", 32'(d), 32'(expm[0]));
    rd_at("R2 stored", 16'h0045);

    for (int o = 0; o < 3; o++) begin
      pio_rd(2'(o), d, v);
      chk("R3 other slot ff", 32'(d), 32'hFF);
      chk("R3 other slot rvalid", 32'(v), 1);
    end

    // out of range: R8
    set_ptr(16'h0100); pio_wr(2'd3, 8'h11);
    rd_at("R8 out of range read", 16'h0100);
    rd_at("R8 no alias", 16'h0000);
    rd_at("R8 top address", 16'hFFFF);
    mm_op(2'd0, 1'b1, 16'h0100, 32'h33, rd, lat);
    rd_at("R8 mm write no alias", 16'h0000);
    mm_check("R8 mm read high", 2'd0, 1'b0, 16'h0200, 0);

    // fencing: R4 R5
    toggle(1'b0);
    foreach (expm[i]) if (i == 8'h1F || i == 8'h20 || i == 8'h2F || i == 8'h30) begin
      set_ptr(16'(i)); pio_wr(2'd3, 8'hEE); model_wr(16'(i), 8'hEE);
    end
    for (int a = 16'h1C; a < 16'h44; a++) rd_at("R4 lock0 window", 16'(a));
    toggle(1'b0);
    for (int a = 16'h1E; a < 16'h32; a++) rd_at("R5 toggle back", 16'(a));
    toggle(1'b1);
    for (int a = 16'h1C; a < 16'h44; a++) rd_at("R4 lock1 window", 16'(a));
    toggle(1'b0);
    for (int a = 16'h1E; a < 16'h42; a += 3) rd_at("R4 both locks", 16'(a));
    toggle(1'b1); toggle(1'b0);

    // memory-mapped widths: R7 R9
    mm_check("R7 word write", 2'd2, 1'b1, 16'h0060, 32'h11223344);
    for (int a = 16'h60; a < 16'h64; a++) rd_at("R7 word bytes", 16'(a));
    mm_check("R7 half write", 2'd1, 1'b1, 16'h0050, 32'h0000A1B2);
    rd_at("R7 half msb", 16'h0050); rd_at("R7 half lsb", 16'h0051);
    mm_check("R7 byte write", 2'd0, 1'b1, 16'h0058, 32'h0000007E);
    rd_at("R7 byte", 16'h0058);
    mm_check("R7 word read", 2'd2, 1'b0, 16'h0080, 0);
    mm_check("R7 half read", 2'd1, 1'b0, 16'h0091, 0);
    mm_check("R7 byte read", 2'd0, 1'b0, 16'h00A7, 0);
    mm_check("R7 size3 word", 2'd3, 1'b0, 16'h0090, 0);
    mm_check("R7 wrap read", 2'd2, 1'b0, 16'hFFFE, 0);
    toggle(1'b0);
    mm_check("R9 split read", 2'd2, 1'b0, 16'h002E, 0);
    mm_check("R9 split write", 2'd2, 1'b1, 16'h002E, 32'hDEADBEEF);
    toggle(1'b0);
    mm_check("R9 after unlock", 2'd2, 1'b0, 16'h002E, 0);

    // busy ignores the port: R10
    set_ptr(16'h0070);
    @(negedge clk); mm_req = 1; mm_we = 0; mm_size = 2'd2; mm_addr = 16'h00C0;
    @(posedge clk); @(negedge clk); mm_req = 0;
    pio_valid = 1; pio_we = 1; pio_off = 2'd0; pio_wdata = 8'h05;
    @(posedge clk); @(negedge clk); pio_valid = 0; pio_we = 0;
    chk("R10 busy seen", 32'(mm_busy), 1);
    while (!mm_done) @(negedge clk);
    pio_rd(2'd3, d, v);
    chk("R10 pointer unchanged", 32'(d), 32'(expm[8'h70]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule